// File: doc/BRIEF.md
# Uniform Requantizer with Top Saturation

This block takes a wide unsigned sample and reduces it to a narrower unsigned output code using uniform, round-to-nearest quantization. The decision points sit half an output step above each nominal level. Code 0 therefore covers everything below half a step, and each later code covers one full step centred on its own level. A sample whose rounded value would pass the largest code is held at that code and flagged as clipped. An unsigned input cannot fall below the smallest code, so at the bottom the result stays at code 0.

Along with the code, the block reports the signed quantization error. This is the level rebuilt from the code minus the input. Code, error and clip flag are captured in one register stage, and a valid flag marks the cycle after an accepted sample. A two-state controller tracks whether that register holds a fresh result. In state EMPTY no new result is present. In state HELD the register was loaded at the previous edge. The transition EMPTY->HELD (LOAD) happens on a cycle with in_valid high. HELD->HELD (STREAM) happens when in_valid stays high. HELD->EMPTY (DRAIN) happens when in_valid falls. EMPTY->EMPTY (IDLE) happens while in_valid stays low.

Top module: `uniform_requantizer`

## Requirements
- R1: After reset (rst_n low, asynchronous), out_valid, out_code, out_err and out_clip are all zero.
- R2: With the default widths (12-bit input, 4-bit code, step 256), the code is the input plus 128 with the low 8 bits dropped. Inputs 0..127 give code 0, inputs 128..383 give code 1, and each later code spans 256 further input values.
- R3: When the input plus 128, shifted right by 8, exceeds 15 (that is, for inputs 3968 and above), out_code is 15 (all ones) and out_clip is 1. For every smaller input out_clip is 0, and 3967 still yields code 15 with out_clip 0.
- R4: out_err is a 9-bit two's complement value equal to out_code*256 minus the sample. For samples with out_clip 0 it lies in [-127, +128].
- R5: A sample presented with in_valid high at a rising edge appears on out_code, out_err and out_clip after that edge, and out_valid is 1 during the following cycle.
- R6: A cycle with in_valid low leaves out_code, out_err and out_clip unchanged, whatever in_sample carries.
- R7: out_valid is 1 exactly in state HELD. A cycle without in_valid takes the controller to EMPTY (out_valid 0), and a new in_valid returns it to HELD.
- R8: Samples on consecutive cycles each produce their own result on consecutive cycles, with out_valid staying 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample on in_sample is to be taken this cycle |
| in_sample | input | IN_W (12) | Unsigned high-resolution sample |
| out_valid | output | 1 | Registered result is fresh this cycle |
| out_code | output | OUT_W (4) | Quantized unsigned code |
| out_err | output | IN_W-OUT_W+1 (9) | Signed error, rebuilt level minus input |
| out_clip | output | 1 | Sample was saturated to the top code |

## Verification
Saturation and the error term fall in the same cycle whenever a sample lands at or above the top threshold. The clip flag rises there, and the error leaves its half-step bound. The bench drives 3967, 3968 and 4095 back to back and judges code, flag and error on each. It requires the error bound only where the flag is low. A second overlap comes from a clipped result that is being held while in_valid drops and the input bus changes. The bench checks that the flag and code persist as out_valid falls.

// File: rtl/requant_pkg.sv
package requant_pkg;

    // Occupancy of the single output register stage.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } stage_state_t;

endpackage

// File: rtl/requant_round.sv
// Round-half-up of the coarse part plus top-end saturation.
module requant_round #(
    parameter int OUT_W = 4
) (
    input  logic [OUT_W-1:0] coarse,   // input bits above the dropped part
    input  logic             guard,    // first dropped bit (weight = half a step)
    output logic [OUT_W-1:0] code,
    output logic             clip
);
    localparam logic [OUT_W-1:0] CODE_MAX = {OUT_W{1'b1}};

    logic [OUT_W:0] rounded;

    // Adding half a step then truncating is the same as adding the guard bit.
    always_comb begin
        rounded = {1'b0, coarse} + {{OUT_W{1'b0}}, guard};
        clip    = rounded[OUT_W];
        code    = clip ? CODE_MAX : rounded[OUT_W-1:0];
    end

    // R3: the carry out can only come from the all-ones coarse value
    always_comb begin
        if (clip) a_r3_carry_from_top: assert (coarse == CODE_MAX && guard);
    end
endmodule

// File: rtl/requant_err.sv
// Error = (code << SH) - sample. The true difference always fits in SH+1
// signed bits, so only the low SH+1 bits of both operands take part.
module requant_err #(
    parameter int SH = 8
) (
    input  logic               code_lsb,
    input  logic [SH:0]        sample_low,
    output logic signed [SH:0] err
);
    logic [SH:0] recon_low;

    always_comb begin
        recon_low = {code_lsb, {SH{1'b0}}};
        err       = $signed(recon_low - sample_low);
    end
endmodule

// File: rtl/requant_ctrl.sv
module requant_ctrl
    import requant_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic load,
    output logic out_valid
);
    stage_state_t state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    // Transitions: LOAD, STREAM, DRAIN, IDLE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: state_nx = in_valid ? ST_HELD : ST_EMPTY;
            ST_HELD:  state_nx = in_valid ? ST_HELD : ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        load      = in_valid;
        out_valid = (state == ST_HELD);
    end

    // R7: an accepted sample always leaves the stage occupied
    a_r7_held_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> state == ST_HELD);
    // R7: a gap always empties the stage
    a_r7_empty_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> state == ST_EMPTY);
endmodule

// File: rtl/uniform_requantizer.sv
module uniform_requantizer #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 4,
    localparam int SH    = IN_W - OUT_W,
    localparam int ERR_W = SH + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_sample,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_code,
    output logic signed [ERR_W-1:0] out_err,
    output logic                    out_clip
);
    localparam int HALF       = 1 << (SH - 1);
    localparam int CLIP_START = ((1 << OUT_W) - 1) * (1 << SH) + HALF;

    generate
        if (SH < 1) begin : g_bad_widths
            initial $error("IN_W must exceed OUT_W");
        end
    endgenerate

    logic                    load;
    logic [OUT_W-1:0]        code_c;
    logic                    clip_c;
    logic signed [ERR_W-1:0] err_c;

    requant_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .load      (load),
        .out_valid (out_valid)
    );

    requant_round #(.OUT_W(OUT_W)) u_round (
        .coarse (in_sample[IN_W-1:SH]),
        .guard  (in_sample[SH-1]),
        .code   (code_c),
        .clip   (clip_c)
    );

    requant_err #(.SH(SH)) u_err (
        .code_lsb   (code_c[0]),
        .sample_low (in_sample[SH:0]),
        .err        (err_c)
    );

    // Result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_code <= '0;
            out_err  <= '0;
            out_clip <= 1'b0;
        end else if (load) begin
            out_code <= code_c;
            out_err  <= err_c;
            out_clip <= clip_c;
        end
    end

    // R5: one cycle of latency on the valid flag
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R6: a gap leaves every result field untouched
    a_r6_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code) && $stable(out_err) && $stable(out_clip));
    // R3: no flag below the top threshold, flag at or above it
    a_r3_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_clip == ($past({1'b0, in_sample}) >= (IN_W+1)'(CLIP_START)));
    // R3: a flagged result carries the top code
    a_r3_clip_top: assert property (@(posedge clk) disable iff (!rst_n)
        out_clip |-> out_code == {OUT_W{1'b1}});
    // R4: unclipped error stays inside half a step
    a_r4_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_clip) |-> (out_err >= -(HALF - 1) && out_err <= HALF));
endmodule

// File: tb/sim_uniform_requantizer.sv
`timescale 1ns/1ps
module sim_uniform_requantizer;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [11:0]       in_sample = '0;
    logic              out_valid;
    logic [3:0]        out_code;
    logic signed [8:0] out_err;
    logic              out_clip;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    uniform_requantizer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_code(out_code), .out_err(out_err),
        .out_clip(out_clip)
    );

    // {sample[16:5], code[4:1], clip[0]} from R2/R3
    localparam int NV = 13;
    localparam logic [16:0] VEC [NV] = '{
        {12'd0,    4'd0,  1'b0},
        {12'd127,  4'd0,  1'b0},
        {12'd128,  4'd1,  1'b0},
        {12'd255,  4'd1,  1'b0},
        {12'd383,  4'd1,  1'b0},
        {12'd384,  4'd2,  1'b0},
        {12'd1000, 4'd4,  1'b0},
        {12'd1920, 4'd8,  1'b0},
        {12'd2047, 4'd8,  1'b0},
        {12'd3839, 4'd15, 1'b0},
        {12'd3967, 4'd15, 1'b0},
        {12'd3968, 4'd15, 1'b1},
        {12'd4095, 4'd15, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_code",  int'(out_code), 0);
        chk("R1 out_err",   int'(out_err), 0);
        chk("R1 out_clip",  int'(out_clip), 0);
        rst_n = 1'b1;

        // Table walk, back to back (R2, R3, R4, R5, R8)
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            in_valid  = 1'b1;
            in_sample = VEC[i][16:5];
            @(negedge clk);
            chk("R5/R8 out_valid", int'(out_valid), 1);
            chk("R2 out_code", int'(out_code), int'(VEC[i][4:1]));
            chk("R3 out_clip", int'(out_clip), int'(VEC[i][0]));
            chk("R4 out_err", int'(out_err), int'(VEC[i][4:1]) * 256 - int'(VEC[i][16:5]));
            if (!VEC[i][0])
                chk("R4 bound", int'(out_err >= -127 && out_err <= 128), 1);
        end

        // R6/R7: gap with a changing bus; clipped result must persist
        in_valid  = 1'b0;
        in_sample = 12'd300;
        @(negedge clk);
        chk("R7 DRAIN out_valid", int'(out_valid), 0);
        chk("R6 code held", int'(out_code), 15);
        chk("R6 clip held", int'(out_clip), 1);
        chk("R6 err held", int'(out_err), 15 * 256 - 4095);
        in_sample = 12'd10;
        @(negedge clk);
        chk("R7 IDLE out_valid", int'(out_valid), 0);
        chk("R6 code still held", int'(out_code), 15);

        // R7: LOAD out of EMPTY
        in_valid  = 1'b1;
        in_sample = 12'd128;
        @(negedge clk);
        chk("R7 LOAD out_valid", int'(out_valid), 1);
        chk("R2 threshold code", int'(out_code), 1);
        chk("R4 err at threshold", int'(out_err), 128);
        in_valid = 1'b0;

        // R1: reset during operation
        in_sample = 12'd4000;
        in_valid  = 1'b1;
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 mid out_valid", int'(out_valid), 0);
        chk("R1 mid out_code",  int'(out_code), 0);
        chk("R1 mid out_clip",  int'(out_clip), 0);
        chk("R1 mid out_err",   int'(out_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule